// File: doc/BRIEF.md
# Fixed Off-Time Chopping Controller for One H-Bridge

This block holds the current in one motor winding near a target by switching the bridge between drive and decay. While the bridge drives, an external comparator reports when the sensed current has reached the target. The controller then turns every switch off for a dead gap and lets the current decay for a fixed off-time. After another dead gap it drives again. The comparator is ignored for a blanking window at the start of each drive, so switching transients cannot end a drive early.

The off-time comes from a two-bit decoded three-level select, with three lengths to choose from. The decay style is slow (both low sides on), fast (the bridge reversed) or mixed (fast for the first quarter of the off-time, then slow). The controller also scales the sine code sent to the external reference DAC by a 3-bit torque setting in eighths of full scale.

Every duration is given in clock cycles by a parameter. The analog comparator, the DAC and the power switches sit outside the block.

Top module: `chop_ctrl`

States: `ST_IDLE` (all off), `ST_GAP` (dead gap, all off), `ST_BLANK` (drive, trip masked), `ST_DRIVE` (drive, trip watched), `ST_OFF` (decay). Transitions:
- idle→gap when `run_en` rises.
- gap→blank or gap→off after DEAD_CYC cycles.
- blank→drive after BLANK_CYC cycles.
- drive→gap on `trip`.
- off→gap after the selected off-time.
- any state→idle when `run_en` is low.

## Requirements
- R1: While reset is asserted and at its release, `gate` is 4'b0000 and `dac_code` is 0.
- R2: When `run_en` is low, `gate` is 4'b0000 from the next cycle. When `run_en` goes high, `gate` stays 0000 for DEAD_CYC cycles before the drive pattern appears. `gate` is {high A, low A, high B, low B}. The drive pattern is 4'b1001 when `dir`=1 and 4'b0110 when `dir`=0. `dir` is sampled as each drive's leading dead gap begins.
- R3: The drive pattern lasts BLANK_CYC cycles with `trip` ignored. If `trip` is high in the first cycle after blanking, drive ends after that cycle, giving a drive run of BLANK_CYC+1 cycles.
- R4: While `trip` stays low after blanking, the drive pattern is held indefinitely.
- R5: `toff_sel` is sampled on the trip. 2'b00 (pin low) selects T_MID, 2'b01 (pin high) selects T_LONG, and 2'b10 (pin floating) or 2'b11 selects T_SHORT.
- R6: With `decay_sel`=2'b00 (slow), `gate` is 4'b0101 for the whole off-time.
- R7: With `decay_sel`=2'b01 (fast), `gate` holds the opposite drive pattern for the whole off-time.
- R8: With `decay_sel`=2'b10 or 2'b11 (mixed), off-time T is split in three parts: fast for floor(T/4) cycles, then 0000 for DEAD_CYC cycles, then slow for the rest.
- R9: `trip` has no effect during the off-time or a dead gap. The off-time always runs its full length.
- R10: `gate` never switches directly between two different non-off patterns; it always passes through DEAD_CYC cycles of 0000. No leg ever has both its high and low switch on.
- R11: `dac_code` = (`sine_code` × (`torque`+1)) >> 3, one clock after the inputs. Torque 7 passes the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | High to let the bridge chop, low forces all switches off |
| dir | input | 1 | Winding current polarity for drive |
| trip | input | 1 | Comparator: sensed current at or above target |
| toff_sel | input | 2 | Decoded three-level off-time select |
| decay_sel | input | 2 | Decay style: 00 slow, 01 fast, 1x mixed |
| sine_code | input | CODE_W | Unscaled current target from the indexer |
| torque | input | 3 | Torque scale in eighths minus one |
| gate | output | 4 | Switch controls {high A, low A, high B, low B} |
| dac_code | output | CODE_W | Scaled target for the reference DAC |

## Verification
The bench builds the block with off-times of 8, 16 and 24 cycles, a blanking window of 4 cycles and a dead gap of 2 cycles. With these values a full drive–gap–decay–gap–drive cycle fits in a few dozen clocks, so every off-time choice, every decay style and both directions can be followed run by run. A 16- or 24-cycle off-time also divides by four exactly, while 8 leaves a slow tail of only 4 cycles. This makes the mixed split, including its internal dead gap, visible at full resolution.

// File: rtl/chop_pkg.sv
package chop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_BLANK = 3'd2,
        ST_DRIVE = 3'd3,
        ST_OFF   = 3'd4
    } chop_state_t;

    // switch patterns {hi_a, lo_a, hi_b, lo_b}
    localparam logic [3:0] PAT_NONE = 4'b0000;
    localparam logic [3:0] PAT_FWD  = 4'b1001;
    localparam logic [3:0] PAT_REV  = 4'b0110;
    localparam logic [3:0] PAT_SLOW = 4'b0101;

    localparam logic [1:0] DK_SLOW = 2'b00;
    localparam logic [1:0] DK_FAST = 2'b01;
endpackage

// File: rtl/chop_toff_sel.sv
module chop_toff_sel #(
    parameter int T_SHORT = 2500,
    parameter int T_MID   = 5000,
    parameter int T_LONG  = 7500,
    parameter int CW      = 13
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] off_cyc
);
    always_comb begin
        unique case (sel)
            2'b00:   off_cyc = CW'(T_MID);
            2'b01:   off_cyc = CW'(T_LONG);
            default: off_cyc = CW'(T_SHORT);
        endcase
    end
endmodule

// File: rtl/chop_torque.sv
module chop_torque #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sine_code,
    input  logic [2:0]        torque,
    output logic [CODE_W-1:0] dac_code
);
    localparam int PW = CODE_W + 3;

    logic [PW-1:0] prod;

    always_comb begin
        prod = PW'(sine_code) * (PW'(torque) + PW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dac_code <= '0;
        else        dac_code <= prod[PW-1:3];
    end
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int BLANK_CYC = 250,
    parameter int DEAD_CYC  = 50,
    parameter int CW        = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          dir,
    input  logic          trip,
    input  logic [CW-1:0] off_cyc,
    input  logic [1:0]    decay_sel,
    output logic [3:0]    gate,
    output chop_state_t   state_o
);
    chop_state_t st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] off_len;
    logic          to_off;
    logic          dir_q;
    logic [1:0]    mode_q;
    logic [CW-1:0] quarter;
    logic [3:0]    drv_pat;
    logic [3:0]    fast_pat;

    assign state_o = st;

    // state register with its timers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            off_len <= '0;
            to_off  <= 1'b0;
            dir_q   <= 1'b0;
            mode_q  <= DK_SLOW;
        end else if (!run_en) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    st     <= ST_GAP;
                    to_off <= 1'b0;
                    dir_q  <= dir;
                    cnt    <= '0;
                end
                ST_GAP: begin
                    if (cnt == CW'(DEAD_CYC - 1)) begin
                        cnt <= '0;
                        st  <= to_off ? ST_OFF : ST_BLANK;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_BLANK: begin
                    if (cnt == CW'(BLANK_CYC - 1)) begin
                        cnt <= '0;
                        st  <= ST_DRIVE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_DRIVE: begin
                    if (trip) begin
                        st      <= ST_GAP;
                        to_off  <= 1'b1;
                        off_len <= off_cyc;
                        mode_q  <= decay_sel;
                        cnt     <= '0;
                    end
                end
                ST_OFF: begin
                    if (cnt == off_len - CW'(1)) begin
                        st     <= ST_GAP;
                        to_off <= 1'b0;
                        dir_q  <= dir;
                        cnt    <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // switch pattern per state
    always_comb begin
        quarter  = off_len >> 2;
        drv_pat  = dir_q ? PAT_FWD : PAT_REV;
        fast_pat = dir_q ? PAT_REV : PAT_FWD;
        gate     = PAT_NONE;
        unique case (st)
            ST_IDLE, ST_GAP: gate = PAT_NONE;
            ST_BLANK, ST_DRIVE: gate = drv_pat;
            ST_OFF: begin
                if (mode_q == DK_SLOW)      gate = PAT_SLOW;
                else if (mode_q == DK_FAST) gate = fast_pat;
                else if (cnt < quarter)     gate = fast_pat;
                else if (cnt < quarter + CW'(DEAD_CYC)) gate = PAT_NONE;
                else                        gate = PAT_SLOW;
            end
            default: gate = PAT_NONE;
        endcase
    end
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
    import chop_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int T_SHORT   = 2500,
    parameter int T_MID     = 5000,
    parameter int T_LONG    = 7500,
    parameter int BLANK_CYC = 250,
    parameter int DEAD_CYC  = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              dir,
    input  logic              trip,
    input  logic [1:0]        toff_sel,
    input  logic [1:0]        decay_sel,
    input  logic [CODE_W-1:0] sine_code,
    input  logic [2:0]        torque,
    output logic [3:0]        gate,
    output logic [CODE_W-1:0] dac_code
);
    localparam int CW = $clog2(T_LONG + BLANK_CYC + DEAD_CYC + 1);

    logic [CW-1:0] off_cyc;
    chop_state_t   st;

    chop_toff_sel #(
        .T_SHORT(T_SHORT), .T_MID(T_MID), .T_LONG(T_LONG), .CW(CW)
    ) toff_i (
        .sel     (toff_sel),
        .off_cyc (off_cyc)
    );

    chop_fsm #(
        .BLANK_CYC(BLANK_CYC), .DEAD_CYC(DEAD_CYC), .CW(CW)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .dir       (dir),
        .trip      (trip),
        .off_cyc   (off_cyc),
        .decay_sel (decay_sel),
        .gate      (gate),
        .state_o   (st)
    );

    chop_torque #(.CODE_W(CODE_W)) torque_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sine_code (sine_code),
        .torque    (torque),
        .dac_code  (dac_code)
    );
endmodule

// File: rtl/chop_ctrl_chk.sv
module chop_ctrl_chk
    import chop_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [3:0]        gate,
    input chop_state_t       st,
    input logic [CODE_W-1:0] sine_code,
    input logic [2:0]        torque,
    input logic [CODE_W-1:0] dac_code
);
    assert_no_leg_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gate[3:2] != 2'b11) && (gate[1:0] != 2'b11));

    assert_dead_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(gate) != 4'b0000 && gate != 4'b0000) |-> (gate == $past(gate)));

    assert_stop_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (gate == 4'b0000));

    assert_blank_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BLANK) |=> (st == ST_BLANK || st == ST_DRIVE || st == ST_IDLE));

    assert_off_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |=> (st == ST_OFF || st == ST_GAP || st == ST_IDLE));

    assert_full_scale_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (torque == 3'd7) |=> (dac_code == $past(sine_code)));
endmodule

bind chop_ctrl chop_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .gate      (gate),
    .st        (st),
    .sine_code (sine_code),
    .torque    (torque),
    .dac_code  (dac_code)
);

// File: tb/chop_ctrl_tb_top.sv
module chop_ctrl_tb_top;
    localparam int CODE_W = 8;
    localparam int TS = 8, TM = 16, TL = 24, BL = 4, DG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0, dir = 1'b1, trip = 1'b0;
    logic [1:0] toff_sel = 2'b00, decay_sel = 2'b00;
    logic [CODE_W-1:0] sine_code = '0;
    logic [2:0] torque = 3'd0;
    logic [3:0] gate;
    logic [CODE_W-1:0] dac_code;

    always #2 clk = ~clk;

    chop_ctrl #(
        .CODE_W(CODE_W), .T_SHORT(TS), .T_MID(TM), .T_LONG(TL),
        .BLANK_CYC(BL), .DEAD_CYC(DG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .dir(dir), .trip(trip),
        .toff_sel(toff_sel), .decay_sel(decay_sel), .sine_code(sine_code),
        .torque(torque), .gate(gate), .dac_code(dac_code)
    );

    typedef struct {
        logic [3:0] pat;
        int         len;
        string      req;
    } run_t;

    run_t exp_q[$];
    int   n_vec = 0, n_bad = 0;
    bit   done = 1'b0;
    bit   mon_on = 1'b0, started = 1'b0;
    logic [3:0] cur_pat = 4'b0000;
    int   cur_len = 0;

    task automatic push(input logic [3:0] p, input int l, input string r);
        run_t it;
        it.pat = p; it.len = l; it.req = r;
        exp_q.push_back(it);
    endtask

    // monitor: cut gate into runs and compare against the queue
    always @(negedge clk) begin
        if (mon_on) begin
            if (!started) begin
                if (gate != 4'b0000) begin
                    started = 1'b1; cur_pat = gate; cur_len = 1;
                end
            end else if (gate == cur_pat) begin
                cur_len++;
            end else begin
                if (exp_q.size() > 0) begin
                    run_t it;
                    it = exp_q.pop_front();
                    n_vec++;
                    if (it.pat !== cur_pat || it.len != cur_len) begin
                        n_bad++;
                        $display("FAIL %s: run pattern %b length %0d, expected %b length %0d",
                                 it.req, cur_pat, cur_len, it.pat, it.len);
                    end
                end
                cur_pat = gate; cur_len = 1;
            end
        end
    end

    task automatic check(input logic [7:0] got, input logic [7:0] expv, input string r);
        n_vec++;
        if (got !== expv) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", r, got, expv);
        end
    endtask

    // one chopping cycle with trip held high
    task automatic run_seq(input logic d, input logic [1:0] ts, input logic [1:0] ds, input int t);
        logic [3:0] drv, fst;
        @(negedge clk);
        mon_on = 1'b0; rst_n = 1'b0;
        dir = d; toff_sel = ts; decay_sel = ds; trip = 1'b1; run_en = 1'b1;
        repeat (3) @(negedge clk);
        drv = d ? 4'b1001 : 4'b0110;
        fst = d ? 4'b0110 : 4'b1001;
        push(drv, BL + 1, "R3");
        push(4'b0000, DG, "R10");
        if (ds == 2'b00) push(4'b0101, t, "R6");
        else if (ds == 2'b01) push(fst, t, "R7");
        else begin
            push(fst, t / 4, "R8");
            push(4'b0000, DG, "R8");
            push(4'b0101, t - t / 4 - DG, "R8");
        end
        push(4'b0000, DG, "R9");
        push(drv, BL + 1, "R5");
        started = 1'b0; cur_len = 0; cur_pat = 4'b0000;
        mon_on = 1'b1; rst_n = 1'b1;
        for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL R5: %0d runs not seen, expected 0", exp_q.size());
            exp_q.delete();
        end
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({4'b0, gate}, 8'h00, "R1");
        check(dac_code, 8'h00, "R1");

        run_seq(1'b1, 2'b00, 2'b00, TM);
        run_seq(1'b1, 2'b10, 2'b01, TS);
        run_seq(1'b0, 2'b01, 2'b10, TL);
        run_seq(1'b1, 2'b11, 2'b11, TS);
        run_seq(1'b0, 2'b00, 2'b01, TM);

        // R4: trip low holds drive; R2: stop and restart
        @(negedge clk);
        rst_n = 1'b0; trip = 1'b0; dir = 1'b1; run_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check({4'b0, gate}, 8'h00, "R1");
        repeat (40) @(negedge clk);
        check({4'b0, gate}, 8'h09, "R4");
        repeat (20) @(negedge clk);
        check({4'b0, gate}, 8'h09, "R4");
        run_en = 1'b0;
        @(negedge clk);
        check({4'b0, gate}, 8'h00, "R2");
        dir = 1'b0; run_en = 1'b1;
        repeat (2) @(negedge clk);
        check({4'b0, gate}, 8'h00, "R2");
        @(negedge clk);
        check({4'b0, gate}, 8'h06, "R2");

        // R11 torque scaling
        sine_code = 8'd200; torque = 3'd7;
        @(negedge clk); check(dac_code, 8'd200, "R11");
        torque = 3'd0;
        @(negedge clk); check(dac_code, 8'd25, "R11");
        torque = 3'd3;
        @(negedge clk); check(dac_code, 8'd100, "R11");
        sine_code = 8'd255; torque = 3'd6;
        @(negedge clk); check(dac_code, 8'd223, "R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule